// File: doc/BRIEF.md
# Eight-Region Memory Protection Unit

This block decides, for every memory access a processor core makes, whether the access may proceed and which caching attributes apply to it. Software programs eight address windows. Each window has a base, a power-of-two size and an enable bit. Two packed permission words give every window a 4-bit rights code for data and another for instruction fetch. Three per-window masks and three control bits select data caching, write buffering and instruction caching. The unit works at 4 KB page granularity, so the access port carries the page number of the address rather than the full byte address.

Each access gives a page number, an access kind and a privilege flag. The unit returns a verdict one clock later: allow or deny, plus the data-cacheable, write-buffered and code-cacheable attributes. A denied data access raises a one-cycle data abort. A denied fetch raises a one-cycle prefetch abort instead. When windows overlap, the window with the higher index wins. When the unit is switched off, every access is allowed.

Top module: `mpu_region_guard`

## Requirements
- R1: Window register layout: bit 0 enables the window, bits 5:1 hold N, and bits 31:12 hold the base page. The window covers 2 << N bytes from the base. It matches a page p when base <= p < base + (2 << N)/4096. If N < 11 the window covers no page.
- R2: Data rights use the window's nibble at bits 4n+3:4n of the data permission word. Code 3 gives read/write at both levels. Code 1 gives privileged read/write only. Code 2 gives privileged read/write and user read. Code 6 gives read only at both levels. Code 5 gives privileged read only. Codes 0, 4 and 7 to 15 give nothing.
- R3: Fetch rights use the same nibble position in the code permission word. Codes 2, 3 and 6 allow fetch at both levels. Codes 1 and 5 allow privileged fetch only. All other codes allow no fetch.
- R4: When several enabled windows match a page, the window with the highest index alone supplies the rights and attributes.
- R5: With control bit 0 clear, every access is allowed. In that state data-cacheable and write-buffered both equal control bit 2, and code-cacheable equals control bit 12. This is also the state after reset.
- R6: With control bit 0 set, a page matched by no enabled window is denied for every access kind, with all attributes low.
- R7: Data-cacheable is control bit 2 AND the winning window's bit in the data-cache mask. Write-buffered is data-cacheable AND the window's bit in the write-buffer mask.
- R8: Code-cacheable is control bit 12 AND the winning window's bit in the code-cache mask.
- R9: Access kind 0 is a data read and kind 1 is a data write. Kinds 2 and 3 are instruction fetches. A denied read or write raises data_abort, and a denied fetch raises fetch_abort. Each is high for exactly the result cycle, and the two are never high together.
- R10: The result of an access presented at one rising edge appears after that edge, with res_valid high for one cycle. With no access presented, res_valid and both aborts stay low. A configuration write takes effect for an access presented at the next edge.
- R11: Configuration select values: 0 to 7 are the window registers, 8 the data permission word, 9 the code permission word, 10 the data-cache mask, 11 the write-buffer mask, 12 the code-cache mask and 13 the control word. Masks use bits 7:0. Selects 14 and 15 change nothing. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_page | input | 20 | Page number (address bits 31:12) |
| acc_kind | input | 2 | 0 read, 1 write, 2/3 fetch |
| acc_priv | input | 1 | 1 for privileged access |
| res_valid | output | 1 | Verdict valid |
| res_allow | output | 1 | Access permitted |
| res_dcache | output | 1 | Data-cacheable attribute |
| res_wbuf | output | 1 | Write-buffered attribute |
| res_icache | output | 1 | Code-cacheable attribute |
| data_abort | output | 1 | Denied data access pulse |
| fetch_abort | output | 1 | Denied fetch pulse |

## Verification
There is one register between the access inputs and every result output, so a verdict is due one edge after the access is sampled. The bench drives each access on a falling edge, samples all seven outputs just after the following rising edge, and then removes the access. After some denied accesses it also samples one edge later to confirm that the aborts are single-cycle pulses. Configuration writes complete one full cycle before the next access, which exercises the rule that a write takes effect at the next access edge.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef struct packed {
    logic priv_rd;
    logic priv_wr;
    logic user_rd;
    logic user_wr;
    logic priv_fx;
    logic user_fx;
  } rights_t;
endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
  parameter int PAGE_W    = 20,
  parameter int PAGE_BITS = 12
) (
  input  logic              en,
  input  logic [4:0]        size_n,
  input  logic [PAGE_W-1:0] base_page,
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  logic [5:0]        expo;
  logic [5:0]        shamt;
  logic [PAGE_W-1:0] offs;
  logic              big_enough;

  always_comb begin
    expo       = {1'b0, size_n} + 6'd1;
    big_enough = (expo >= 6'(PAGE_BITS));
    shamt      = expo - 6'(PAGE_BITS);
    offs       = page - base_page;
    hit        = en && big_enough && (page >= base_page) && ((offs >> shamt) == '0);
  end
endmodule

// File: rtl/mpu_perm_decode.sv
module mpu_perm_decode
  import mpu_pkg::*;
(
  input  logic [3:0] dcode,
  input  logic [3:0] ccode,
  output rights_t    rights
);
  always_comb begin
    rights = '0;
    unique case (dcode)
      4'd1: begin rights.priv_rd = 1'b1; rights.priv_wr = 1'b1; end
      4'd2: begin rights.priv_rd = 1'b1; rights.priv_wr = 1'b1; rights.user_rd = 1'b1; end
      4'd3: begin rights.priv_rd = 1'b1; rights.priv_wr = 1'b1;
                  rights.user_rd = 1'b1; rights.user_wr = 1'b1; end
      4'd5: rights.priv_rd = 1'b1;
      4'd6: begin rights.priv_rd = 1'b1; rights.user_rd = 1'b1; end
      default: ;
    endcase
    unique case (ccode)
      4'd1, 4'd5:       rights.priv_fx = 1'b1;
      4'd2, 4'd3, 4'd6: begin rights.priv_fx = 1'b1; rights.user_fx = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/mpu_prio_select.sv
module mpu_prio_select #(
  parameter int NUM = 8,
  localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM-1:0] hits,
  output logic           any,
  output logic [IW-1:0]  idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM; i++) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mpu_region_guard.sv
module mpu_region_guard
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int DW          = 32,
  parameter int PAGE_BITS   = 12,
  parameter int SEL_W       = 4,
  parameter int CTL_ON      = 0,
  parameter int CTL_DC      = 2,
  parameter int CTL_IC      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             acc_valid,
  input  logic [DW-PAGE_BITS-1:0] acc_page,
  input  logic [1:0]       acc_kind,
  input  logic             acc_priv,
  output logic             res_valid,
  output logic             res_allow,
  output logic             res_dcache,
  output logic             res_wbuf,
  output logic             res_icache,
  output logic             data_abort,
  output logic             fetch_abort
);
  localparam int PAGE_W    = DW - PAGE_BITS;
  localparam int IW        = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int PERM_W    = 4 * NUM_REGIONS;
  localparam int SEL_DPERM = NUM_REGIONS;
  localparam int SEL_CPERM = NUM_REGIONS + 1;
  localparam int SEL_DCM   = NUM_REGIONS + 2;
  localparam int SEL_WBM   = NUM_REGIONS + 3;
  localparam int SEL_ICM   = NUM_REGIONS + 4;
  localparam int SEL_CTL   = NUM_REGIONS + 5;

  logic              rgn_en_q   [NUM_REGIONS];
  logic [4:0]        rgn_n_q    [NUM_REGIONS];
  logic [PAGE_W-1:0] rgn_base_q [NUM_REGIONS];
  logic [PERM_W-1:0] dperm_q, cperm_q;
  logic [NUM_REGIONS-1:0] dcm_q, wbm_q, icm_q;
  logic ctl_on_q, ctl_dc_q, ctl_ic_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        rgn_en_q[i]   <= 1'b0;
        rgn_n_q[i]    <= '0;
        rgn_base_q[i] <= '0;
      end
      dperm_q  <= '0;
      cperm_q  <= '0;
      dcm_q    <= '0;
      wbm_q    <= '0;
      icm_q    <= '0;
      ctl_on_q <= 1'b0;
      ctl_dc_q <= 1'b0;
      ctl_ic_q <= 1'b0;
    end else if (cfg_we) begin
      if (int'(cfg_sel) < NUM_REGIONS) begin
        rgn_en_q[cfg_sel[IW-1:0]]   <= cfg_wdata[0];
        rgn_n_q[cfg_sel[IW-1:0]]    <= cfg_wdata[5:1];
        rgn_base_q[cfg_sel[IW-1:0]] <= cfg_wdata[DW-1:PAGE_BITS];
      end else if (int'(cfg_sel) == SEL_DPERM) dperm_q <= cfg_wdata[PERM_W-1:0];
      else if (int'(cfg_sel) == SEL_CPERM) cperm_q <= cfg_wdata[PERM_W-1:0];
      else if (int'(cfg_sel) == SEL_DCM)   dcm_q   <= cfg_wdata[NUM_REGIONS-1:0];
      else if (int'(cfg_sel) == SEL_WBM)   wbm_q   <= cfg_wdata[NUM_REGIONS-1:0];
      else if (int'(cfg_sel) == SEL_ICM)   icm_q   <= cfg_wdata[NUM_REGIONS-1:0];
      else if (int'(cfg_sel) == SEL_CTL) begin
        ctl_on_q <= cfg_wdata[CTL_ON];
        ctl_dc_q <= cfg_wdata[CTL_DC];
        ctl_ic_q <= cfg_wdata[CTL_IC];
      end
    end
  end

  logic [NUM_REGIONS-1:0] hits;
  rights_t                rights [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    mpu_region_match #(.PAGE_W(PAGE_W), .PAGE_BITS(PAGE_BITS)) u_match (
      .en       (rgn_en_q[g]),
      .size_n   (rgn_n_q[g]),
      .base_page(rgn_base_q[g]),
      .page     (acc_page),
      .hit      (hits[g])
    );
    mpu_perm_decode u_dec (
      .dcode (dperm_q[4*g +: 4]),
      .ccode (cperm_q[4*g +: 4]),
      .rights(rights[g])
    );
  end

  logic          any_hit;
  logic [IW-1:0] win;

  mpu_prio_select #(.NUM(NUM_REGIONS)) u_prio (
    .hits(hits),
    .any (any_hit),
    .idx (win)
  );

  rights_t wr_r;
  logic    is_fetch, is_write;
  logic    allow_c, dc_c, wb_c, ic_c;

  always_comb begin
    wr_r     = rights[win];
    is_fetch = acc_kind[1];
    is_write = !acc_kind[1] && acc_kind[0];
    if (!ctl_on_q) begin
      allow_c = 1'b1;
      dc_c    = ctl_dc_q;
      wb_c    = ctl_dc_q;
      ic_c    = ctl_ic_q;
    end else begin
      if (!any_hit)      allow_c = 1'b0;
      else if (is_fetch) allow_c = acc_priv ? wr_r.priv_fx : wr_r.user_fx;
      else if (is_write) allow_c = acc_priv ? wr_r.priv_wr : wr_r.user_wr;
      else               allow_c = acc_priv ? wr_r.priv_rd : wr_r.user_rd;
      dc_c = any_hit && ctl_dc_q && dcm_q[win];
      wb_c = dc_c && wbm_q[win];
      ic_c = any_hit && ctl_ic_q && icm_q[win];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !acc_valid) begin
      res_valid   <= 1'b0;
      res_allow   <= 1'b0;
      res_dcache  <= 1'b0;
      res_wbuf    <= 1'b0;
      res_icache  <= 1'b0;
      data_abort  <= 1'b0;
      fetch_abort <= 1'b0;
    end else begin
      res_valid   <= 1'b1;
      res_allow   <= allow_c;
      res_dcache  <= dc_c;
      res_wbuf    <= wb_c;
      res_icache  <= ic_c;
      data_abort  <= !allow_c && !is_fetch;
      fetch_abort <= !allow_c && is_fetch;
    end
  end

  AST_ABORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(data_abort && fetch_abort)); // R9
  AST_ABORT_MEANS_DENY: assert property (@(posedge clk) disable iff (rst)
    (data_abort || fetch_abort) |-> (res_valid && !res_allow)); // R9
  AST_WBUF_NEEDS_DCACHE: assert property (@(posedge clk) disable iff (rst)
    res_wbuf |-> res_dcache); // R7
  AST_OFF_ALLOWS_ALL: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !ctl_on_q) |=> res_allow); // R5
  AST_NO_HIT_DENIED: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ctl_on_q && !(|hits)) |=> !res_allow); // R6
  AST_DCACHE_GATED: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !ctl_dc_q) |=> !res_dcache); // R7
  AST_ICACHE_GATED: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !ctl_ic_q) |=> !res_icache); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!res_valid && !data_abort && !fetch_abort)); // R10
  AST_WINNER_HITS: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> hits[win]); // R4
endmodule

// File: tb/sim_mpu_region_guard.sv
module sim_mpu_region_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [19:0] acc_page = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_priv = 1'b0;
  logic res_valid, res_allow, res_dcache, res_wbuf, res_icache, data_abort, fetch_abort;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] sh_rgn [8];
  logic [31:0] sh_dp, sh_cp, sh_ctl;
  logic [7:0]  sh_dcm, sh_wbm, sh_icm;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_region_guard u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_page(acc_page), .acc_kind(acc_kind), .acc_priv(acc_priv),
    .res_valid(res_valid), .res_allow(res_allow), .res_dcache(res_dcache),
    .res_wbuf(res_wbuf), .res_icache(res_icache),
    .data_abort(data_abort), .fetch_abort(fetch_abort)
  );

  function automatic bit rhit(input logic [31:0] r, input logic [19:0] p);
    longint unsigned pages, bp, ap;
    pages = (64'd2 << r[5:1]) >> 12;
    bp = 64'(r[31:12]);
    ap = 64'(p);
    return r[0] && (pages != 0) && (ap >= bp) && (ap < bp + pages);
  endfunction

  // returns {allow, dcache, wbuf, icache}
  function automatic logic [3:0] model(input logic [19:0] p, input logic [1:0] k, input logic pv);
    bit hit; int w; logic [3:0] d, c;
    bit pr, pw, ur, uw, pf, uf, al, dc, wb, ic;
    if (!sh_ctl[0]) return {1'b1, sh_ctl[2], sh_ctl[2], sh_ctl[12]};
    hit = 0; w = 0;
    for (int r = 0; r < 8; r++) if (rhit(sh_rgn[r], p)) begin hit = 1; w = r; end
    if (!hit) return 4'b0000;
    d = sh_dp[4*w +: 4];
    c = sh_cp[4*w +: 4];
    pr = d inside {4'd1, 4'd2, 4'd3, 4'd5, 4'd6};
    pw = d inside {4'd1, 4'd2, 4'd3};
    ur = d inside {4'd2, 4'd3, 4'd6};
    uw = (d == 4'd3);
    pf = c inside {4'd1, 4'd2, 4'd3, 4'd5, 4'd6};
    uf = c inside {4'd2, 4'd3, 4'd6};
    if (k[1])      al = pv ? pf : uf;
    else if (k[0]) al = pv ? pw : uw;
    else           al = pv ? pr : ur;
    dc = sh_ctl[2] && sh_dcm[w];
    wb = dc && sh_wbm[w];
    ic = sh_ctl[12] && sh_icm[w];
    return {al, dc, wb, ic};
  endfunction

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,allow,dc,wb,ic,dab,fab} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s < 8) sh_rgn[s[2:0]] = d;
    else case (s)
      4'd8:  sh_dp  = d;
      4'd9:  sh_cp  = d;
      4'd10: sh_dcm = d[7:0];
      4'd11: sh_wbm = d[7:0];
      4'd12: sh_icm = d[7:0];
      4'd13: sh_ctl = d;
      default: ;
    endcase
  endtask

  task automatic probe(input string tag, input logic [19:0] p, input logic [1:0] k, input logic pv,
                       input bit idle_check);
    logic [3:0] e;
    e = model(p, k, pv);
    @(negedge clk);
    acc_valid = 1'b1; acc_page = p; acc_kind = k; acc_priv = pv;
    @(posedge clk); #1;
    chk(tag, {res_valid, res_allow, res_dcache, res_wbuf, res_icache, data_abort, fetch_abort},
        {1'b1, e, !e[3] && !k[1], !e[3] && k[1]});
    @(negedge clk);
    acc_valid = 1'b0;
    if (idle_check) begin
      @(posedge clk); #1;
      chk({tag, " R9 R10 pulse ends"},
          {res_valid, res_allow, res_dcache, res_wbuf, res_icache, data_abort, fetch_abort}, 7'b0);
    end
  endtask

  localparam logic [31:0] RB = 32'h0200_0000;

  initial begin
    for (int i = 0; i < 8; i++) sh_rgn[i] = '0;
    sh_dp = '0; sh_cp = '0; sh_ctl = '0; sh_dcm = '0; sh_wbm = '0; sh_icm = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset outputs low",
        {res_valid, res_allow, res_dcache, res_wbuf, res_icache, data_abort, fetch_abort}, 7'b0);
    @(negedge clk); rst = 1'b0;

    // R5: unit off after reset, then with attribute bits
    for (int k = 0; k < 4; k++) probe("R5 off after reset", 20'h12345, 2'(k), 1'b0, 0);
    wr(4'd13, 32'h0000_1004);
    for (int k = 0; k < 4; k++) probe("R5 off with attrs", 20'hABCDE, 2'(k), 1'b1, 0);
    wr(4'd13, 32'h0000_0004);
    probe("R5 off dc only", 20'h00001, 2'd0, 1'b0, 0);

    // R6: on with nothing enabled
    wr(4'd13, 32'h0000_1005);
    for (int k = 0; k < 4; k++) begin
      probe("R6 no region denied", 20'h02000, 2'(k), 1'b1, 1);
      probe("R6 no region denied", 20'h02000, 2'(k), 1'b0, 0);
    end

    // R2 R3 R9 R10: sweep all code pairs in window 3 (16 KB)
    wr(4'd3, RB | (32'd13 << 1) | 32'd1);
    for (int dc = 0; dc < 16; dc++) begin
      for (int cc = 0; cc < 16; cc++) begin
        wr(4'd8, 32'h3333_3333 & ~(32'hF << 12) | (32'(dc) << 12));
        wr(4'd9, 32'h3333_3333 & ~(32'hF << 12) | (32'(cc) << 12));
        for (int pv = 0; pv < 2; pv++)
          for (int k = 0; k < 3; k++)
            probe("R2 R3 R9 R10 code sweep", 20'h02001, 2'(k), 1'(pv), (dc == 0 && cc == 0 && k == 0));
      end
    end
    wr(4'd8, 32'h3333_3333);
    wr(4'd9, 32'h3333_3333);

    // R4: overlap priority
    wr(4'd1, RB | (32'd19 << 1) | 32'd1);            // 1 MB, code 3
    wr(4'd5, (RB + 32'h1000) | (32'd11 << 1) | 32'd1); // 4 KB
    wr(4'd8, 32'h3303_3333);                        // window 5 data 0
    probe("R4 higher window denies", 20'h02001, 2'd0, 1'b1, 0);
    probe("R4 lower window outside overlap", 20'h02002, 2'd0, 1'b1, 0);
    probe("R4 lower window below overlap", 20'h02000, 2'd1, 1'b0, 0);
    wr(4'd8, 32'h3333_3303);                        // window 1 data 0, window 5 data 3
    probe("R4 higher window allows", 20'h02001, 2'd1, 1'b0, 0);
    probe("R4 lower window denies elsewhere", 20'h020F0, 2'd0, 1'b1, 0);
    wr(4'd5, 32'h0);

    // R7 R8: attribute sweep on window 1 (wins at page 0x02080)
    for (int ctl = 0; ctl < 4; ctl++)
      for (int m = 0; m < 8; m++) begin
        wr(4'd13, 32'd1 | (ctl[0] ? 32'h4 : 32'h0) | (ctl[1] ? 32'h1000 : 32'h0));
        wr(4'd10, m[0] ? 32'h02 : 32'hFD);
        wr(4'd11, m[1] ? 32'h02 : 32'hFD);
        wr(4'd12, m[2] ? 32'h02 : 32'hFD);
        probe("R7 R8 attribute sweep", 20'h02080, 2'd0, 1'b1, 0);
        probe("R7 R8 attribute sweep fetch", 20'h02080, 2'd2, 1'b0, 0);
      end

    // R1: size sweep on window 0 at page 0x00100
    wr(4'd1, 32'h0); wr(4'd3, 32'h0);
    wr(4'd8, 32'h3333_3333); wr(4'd13, 32'h1);
    for (int n = 0; n <= 20; n++) begin
      longint unsigned pg;
      pg = (64'd2 << n) >> 12;
      wr(4'd0, 32'h0010_0000 | (32'(n) << 1) | 32'd1);
      probe("R1 size base page", 20'h00100, 2'd0, 1'b1, 0);
      if (pg != 0) begin
        probe("R1 size last page", 20'(64'h100 + pg - 1), 2'd1, 1'b1, 0);
        probe("R1 size past end", 20'(64'h100 + pg), 2'd0, 1'b1, 0);
      end
      probe("R1 size below base", 20'h000FF, 2'd0, 1'b1, 0);
    end
    wr(4'd0, 32'h0010_0000 | (32'd14 << 1));   // disabled window
    probe("R1 enable bit clear", 20'h00100, 2'd0, 1'b1, 0);

    // R11: selects 14 and 15 leave configuration alone
    wr(4'd0, 32'h0010_0000 | (32'd14 << 1) | 32'd1);
    wr(4'd14, 32'hFFFF_FFFF);
    wr(4'd15, 32'h0000_0000);
    probe("R11 unused selects ignored", 20'h00100, 2'd1, 1'b0, 0);
    probe("R11 unused selects ignored", 20'h00105, 2'd2, 1'b0, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule